// File: doc/BRIEF.md
# Timer Event Interrupt and DMA Request Controller

This block sits beside a three-channel timer/counter and converts the counter's one-cycle event strobes into interrupt, DMA-request and event-bus outputs. It takes strobes for counter underflow, counter overflow, each channel's compare match or capture, and each channel's capture-buffer overflow. Every source sets a sticky flag. A maskable interrupt line is driven whenever an enabled flag is set. Software clears flags through a write-one-to-clear register.

Each timer event also raises a DMA request. A request is cleared when software or a DMA engine reads or writes the data register tied to that event. When a control bit allows it, the request is also cleared when the DMA channel it triggered reports active. Neither way of clearing touches the interrupt flags. The event-bus outputs give a one-cycle pulse per event. Each channel can instead be set to a level mode, in which its output follows the compare output. A debug-run control bit selects whether events are accepted while the CPU is halted for debug.

Top module: `tmr_evt_irq_dma`

## Requirements
- R1: After a synchronous active-low reset, irq, dma_req, every event output and bus_rdata are zero, and the control, enable and flag registers are zero.
- R2: An accepted event sets its flag on the next clock edge, and the flag stays set until it is cleared. Flag bit positions are: bit 0 underflow, bit 1 overflow, bits 2..4 compare/capture of channels 0..2, and bits 5..7 capture-buffer overflow of channels 0..2. The flag register is at address 1.
- R3: irq is high in the cycle after any flag bit and its matching enable bit (enable register at address 3, same bit map) are both set, and low otherwise.
- R4: Writing data to address 2 clears every flag whose data bit is 1. If an event sets the same flag in that cycle, the flag stays set.
- R5: With a channel in pulse mode, each accepted underflow, overflow or compare/capture event makes its event output high for exactly the one cycle that follows the event.
- R6: Control bit 2+k selects level mode for channel k. In level mode, evt_cc_o[k] follows cmp_lvl[k] one cycle later, whatever the event strobes do.
- R7: dma_req[0] is set by an accepted underflow or overflow. dma_req[1+k] is set by an accepted compare/capture on channel k. A read or write of address 4 or 5 clears dma_req[0]. A read or write of address 6+2k or 7+2k clears dma_req[1+k]. A set in the same cycle wins over the clear.
- R8: An access that clears a DMA request leaves the flag register unchanged.
- R9: While control bit 1 is set, dma_active[i] high clears dma_req[i]. While control bit 1 is clear, dma_active has no effect.
- R10: While dbg_halt is high and control bit 0 is clear, all event strobes are ignored: no flag, no DMA request and no pulse. With control bit 0 set, events are accepted during the halt.
- R11: The control register (address 0, width 5) and the enable register (address 3) can be written and read back. A read returns its data on bus_rdata in the next cycle, and bus_rdata holds that value until the next read. Every other address reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_halt | input | 1 | CPU halted in debug mode |
| evt_uf | input | 1 | Counter underflow strobe |
| evt_of | input | 1 | Counter overflow strobe |
| evt_cc | input | 3 | Per-channel compare match / capture strobe |
| evt_cbof | input | 3 | Per-channel capture-buffer overflow strobe |
| cmp_lvl | input | 3 | Per-channel compare output level |
| dma_active | input | 4 | Active indication of the DMA channel behind each request |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt request |
| dma_req | output | 4 | DMA requests: bit 0 underflow/overflow, bits 1..3 channels |
| evt_uf_o | output | 1 | Underflow event-bus output |
| evt_of_o | output | 1 | Overflow event-bus output |
| evt_cc_o | output | 3 | Per-channel compare event-bus output |

## Verification
A flag that sets or clears wrongly shows up on irq one cycle later, but only when that flag's enable bit is set. Flag-read checks are spread through the run to catch flags whose enable bit is clear. A DMA request that sticks or drops appears on dma_req at the edge after the access or the active indication. A freeze gate or a mode select that is decoded wrongly shows on the event outputs in the cycle right after the strobe. Random stimulus mixes bus accesses, clears landing on the same cycle as events, and debug halts, and every output is compared against a cycle model each cycle.

// File: rtl/tmr_evt_pkg.sv
// Shared address map and control-bit positions for the timer event controller.
package tmr_evt_pkg;
    localparam int unsigned A_CTRL    = 0;
    localparam int unsigned A_FLAG    = 1;
    localparam int unsigned A_FLAGCLR = 2;
    localparam int unsigned A_ENABLE  = 3;
    localparam int unsigned A_COUNT   = 4;
    localparam int unsigned A_TOPBUF  = 5;
    localparam int unsigned A_CC_BASE = 6;

    localparam int unsigned CB_DBGRUN = 0;
    localparam int unsigned CB_DMACLR = 1;
    localparam int unsigned CB_LVL    = 2;

    // Address of the capture value register of channel k
    function automatic int unsigned cc_val_addr(input int unsigned k);
        return A_CC_BASE + 2 * k;
    endfunction

    // Address of the capture buffer register of channel k
    function automatic int unsigned cc_buf_addr(input int unsigned k);
        return A_CC_BASE + 2 * k + 1;
    endfunction
endpackage

// File: rtl/tmr_evt_regs.sv
// Register bus decode: control and enable registers, flag-clear strobes,
// DMA-clearing access strobes and registered read data.
// Assumes single-cycle rd/wr strobes and that the address map fits ADDR_W.
module tmr_evt_regs
    import tmr_evt_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int NFLAG  = 2 + 2 * NUM_CH,
    parameter int CTRL_W = 2 + NUM_CH,
    parameter int NREQ   = NUM_CH + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NFLAG-1:0]  flags_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [NFLAG-1:0]  enable_o,
    output logic [NFLAG-1:0]  flag_clr_o,
    output logic [NREQ-1:0]   dma_acc_o,
    output logic [DATA_W-1:0] bus_rdata
);
    logic              any_acc;
    logic [DATA_W-1:0] rd_val;
    logic              unused_wdata;

    assign any_acc      = bus_rd | bus_wr;
    assign unused_wdata = ^bus_wdata;

    // Write-one-to-clear strobes for the flag bank
    assign flag_clr_o = (bus_wr && bus_addr == ADDR_W'(A_FLAGCLR)) ? bus_wdata[NFLAG-1:0] : '0;

    // Counter or top-buffer access clears the underflow/overflow request
    assign dma_acc_o[0] = any_acc && (bus_addr == ADDR_W'(A_COUNT) || bus_addr == ADDR_W'(A_TOPBUF));

    for (genvar k = 0; k < NUM_CH; k++) begin : g_acc
        // Capture value or buffer access of channel k clears its request
        assign dma_acc_o[k+1] = any_acc && (bus_addr == ADDR_W'(cc_val_addr(k)) ||
                                            bus_addr == ADDR_W'(cc_buf_addr(k)));
    end

    // Control and enable register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o   <= '0;
            enable_o <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(A_CTRL))   ctrl_o   <= bus_wdata[CTRL_W-1:0];
            if (bus_addr == ADDR_W'(A_ENABLE)) enable_o <= bus_wdata[NFLAG-1:0];
        end
    end

    // Read multiplexer
    always_comb begin
        rd_val = '0;
        if (bus_addr == ADDR_W'(A_CTRL))   rd_val = DATA_W'(ctrl_o);
        if (bus_addr == ADDR_W'(A_FLAG))   rd_val = DATA_W'(flags_i);
        if (bus_addr == ADDR_W'(A_ENABLE)) rd_val = DATA_W'(enable_o);
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end
endmodule

// File: rtl/tmr_evt_flags.sv
// Sticky interrupt flag bank with write-one-to-clear and a registered
// combined interrupt. Assumes set_i is already gated for debug freeze.
module tmr_evt_flags #(
    parameter int NFLAG = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_i,
    input  logic [NFLAG-1:0] clr_i,
    input  logic [NFLAG-1:0] enable_i,
    output logic [NFLAG-1:0] flags_o,
    output logic             irq_o
);
    // Flag update: a set in the same cycle outranks a clear
    always_ff @(posedge clk) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= (flags_o & ~clr_i) | set_i;
    end

    // Interrupt line from the current flags and enables
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(flags_o & enable_i);
    end
endmodule

// File: rtl/tmr_evt_dma.sv
// Per-source DMA request latches, cleared by a register access or,
// optionally, by the triggered DMA channel reporting active.
module tmr_evt_dma #(
    parameter int NREQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] set_i,
    input  logic [NREQ-1:0] acc_i,
    input  logic [NREQ-1:0] active_i,
    input  logic            clr_on_act_i,
    output logic [NREQ-1:0] req_o
);
    for (genvar i = 0; i < NREQ; i++) begin : g_req
        // One request latch: set wins over either clear source
        always_ff @(posedge clk) begin
            if (!rst_n)                                     req_o[i] <= 1'b0;
            else if (set_i[i])                              req_o[i] <= 1'b1;
            else if (acc_i[i] || (clr_on_act_i && active_i[i])) req_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/tmr_evt_out.sv
// Event-bus output stage: registered one-cycle pulses, with a per-channel
// option to follow the compare output level instead.
module tmr_evt_out #(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uf_i,
    input  logic              of_i,
    input  logic [NUM_CH-1:0] cc_i,
    input  logic [NUM_CH-1:0] cmp_i,
    input  logic [NUM_CH-1:0] lvl_i,
    output logic              uf_o,
    output logic              of_o,
    output logic [NUM_CH-1:0] cc_o
);
    // Counter event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf_o <= 1'b0;
            of_o <= 1'b0;
        end else begin
            uf_o <= uf_i;
            of_o <= of_i;
        end
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        // Channel output: level copy or event pulse
        always_ff @(posedge clk) begin
            if (!rst_n) cc_o[k] <= 1'b0;
            else        cc_o[k] <= lvl_i[k] ? cmp_i[k] : cc_i[k];
        end
    end
endmodule

// File: rtl/tmr_evt_irq_dma.sv
// Top of the timer event controller: gates event strobes for debug freeze,
// and feeds the flag bank, DMA request latches and event-bus stage.
// Assumes event strobes are one cycle wide and synchronous to clk.
module tmr_evt_irq_dma
    import tmr_evt_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_halt,
    input  logic              evt_uf,
    input  logic              evt_of,
    input  logic [NUM_CH-1:0] evt_cc,
    input  logic [NUM_CH-1:0] evt_cbof,
    input  logic [NUM_CH-1:0] cmp_lvl,
    input  logic [NUM_CH:0]   dma_active,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic [NUM_CH:0]   dma_req,
    output logic              evt_uf_o,
    output logic              evt_of_o,
    output logic [NUM_CH-1:0] evt_cc_o
);
    localparam int NFLAG  = 2 + 2 * NUM_CH;
    localparam int NREQ   = NUM_CH + 1;
    localparam int CTRL_W = 2 + NUM_CH;

    logic [CTRL_W-1:0] ctrl_q;
    logic [NFLAG-1:0]  enable_q;
    logic [NFLAG-1:0]  flags_q;
    logic [NFLAG-1:0]  flag_clr;
    logic [NREQ-1:0]   dma_acc;
    logic              ev_ok;
    logic [NFLAG-1:0]  ev_set;
    logic [NREQ-1:0]   dma_set;

    // Debug freeze gate on every incoming event
    assign ev_ok   = !dbg_halt || ctrl_q[CB_DBGRUN];
    assign ev_set  = ev_ok ? {evt_cbof, evt_cc, evt_of, evt_uf} : '0;
    assign dma_set = {ev_set[2 +: NUM_CH], ev_set[0] | ev_set[1]};

    tmr_evt_regs #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .NFLAG(NFLAG), .CTRL_W(CTRL_W), .NREQ(NREQ)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .flags_i(flags_q), .ctrl_o(ctrl_q), .enable_o(enable_q),
        .flag_clr_o(flag_clr), .dma_acc_o(dma_acc), .bus_rdata(bus_rdata)
    );

    tmr_evt_flags #(.NFLAG(NFLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(ev_set), .clr_i(flag_clr),
        .enable_i(enable_q), .flags_o(flags_q), .irq_o(irq)
    );

    tmr_evt_dma #(.NREQ(NREQ)) u_dma (
        .clk(clk), .rst_n(rst_n), .set_i(dma_set), .acc_i(dma_acc),
        .active_i(dma_active), .clr_on_act_i(ctrl_q[CB_DMACLR]), .req_o(dma_req)
    );

    tmr_evt_out #(.NUM_CH(NUM_CH)) u_out (
        .clk(clk), .rst_n(rst_n), .uf_i(ev_set[0]), .of_i(ev_set[1]),
        .cc_i(ev_set[2 +: NUM_CH]), .cmp_i(cmp_lvl), .lvl_i(ctrl_q[CB_LVL +: NUM_CH]),
        .uf_o(evt_uf_o), .of_o(evt_of_o), .cc_o(evt_cc_o)
    );
endmodule

// File: rtl/tmr_evt_chk.sv
// Property checker for the timer event controller, bound to the top module.
module tmr_evt_chk
    import tmr_evt_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 4,
    parameter int NFLAG  = 8,
    parameter int CTRL_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dbg_halt,
    input logic              evt_uf,
    input logic [NUM_CH-1:0] evt_cc,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [NUM_CH:0]   dma_active,
    input logic              irq,
    input logic [NUM_CH:0]   dma_req,
    input logic              evt_uf_o,
    input logic [NFLAG-1:0]  flags,
    input logic [NFLAG-1:0]  enable,
    input logic [CTRL_W-1:0] ctrl,
    input logic [NUM_CH:0]   dma_acc
);
    // Flags never fall without a clear write
    p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(A_FLAGCLR)) |=> ((flags & $past(flags)) == $past(flags)));

    // Interrupt follows enabled flags one cycle later
    p_irq_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(flags & enable)));

    // An underflow pulse only follows an underflow strobe
    p_uf_pulse_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_uf_o |-> $past(evt_uf));

    // Frozen strobes produce no pulse
    p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && !ctrl[CB_DBGRUN] && evt_uf) |=> !evt_uf_o);

    for (genvar i = 0; i <= NUM_CH; i++) begin : g_req
        // A request holds until one of its clear conditions
        p_dma_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (dma_req[i] && !dma_acc[i] && !(ctrl[CB_DMACLR] && dma_active[i])) |=> dma_req[i]);
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        // An accepted channel event raises its request
        p_dma_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_cc[k] && (!dbg_halt || ctrl[CB_DBGRUN])) |=> dma_req[k+1]);
    end
endmodule

bind tmr_evt_irq_dma tmr_evt_chk #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .NFLAG(NFLAG), .CTRL_W(CTRL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt), .evt_uf(evt_uf), .evt_cc(evt_cc),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .dma_active(dma_active), .irq(irq),
    .dma_req(dma_req), .evt_uf_o(evt_uf_o), .flags(flags_q), .enable(enable_q),
    .ctrl(ctrl_q), .dma_acc(dma_acc)
);

// File: tb/tb_tmr_evt_irq_dma.sv
module tb_tmr_evt_irq_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt, uf, of;
    logic [2:0]  cc, cb, cmp;
    logic [3:0]  act;
    logic [3:0]  addr;
    logic        rd, wr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq, uf_o, of_o;
    logic [3:0]  dma;
    logic [2:0]  cc_o;

    always #5 clk = ~clk;

    tmr_evt_irq_dma dut (
        .clk(clk), .rst_n(rst_n), .dbg_halt(halt), .evt_uf(uf), .evt_of(of),
        .evt_cc(cc), .evt_cbof(cb), .cmp_lvl(cmp), .dma_active(act),
        .bus_addr(addr), .bus_rd(rd), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata), .irq(irq), .dma_req(dma), .evt_uf_o(uf_o),
        .evt_of_o(of_o), .evt_cc_o(cc_o)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // Cycle model state
    logic [7:0]  m_flags, m_en;
    logic [4:0]  m_ctrl;
    logic [3:0]  m_dma;
    logic        m_irq, m_uf, m_of;
    logic [2:0]  m_cc;
    logic [31:0] m_rdata;

    task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
        n_chk++;
        if (a !== e) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, a, e);
        end
    endtask

    function automatic logic [31:0] f_read(input logic [3:0] a);
        case (a)
            4'd0:    return 32'(m_ctrl);
            4'd1:    return 32'(m_flags);
            4'd3:    return 32'(m_en);
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [3:0] f_acc(input logic [3:0] a, input logic r, input logic w);
        logic [3:0] v;
        v[0] = (r | w) && (a == 4'd4 || a == 4'd5);
        for (int k = 0; k < 3; k++)
            v[k+1] = (r | w) && (a == 4'(6 + 2 * k) || a == 4'(7 + 2 * k));
        return v;
    endfunction

    task automatic model_step();
        logic       ok;
        logic [7:0] gev, clr;
        logic [3:0] dset, dclr;
        ok   = !halt || m_ctrl[0];
        gev  = ok ? {cb, cc, of, uf} : 8'd0;
        clr  = (wr && addr == 4'd2) ? wdata[7:0] : 8'd0;
        dset = {gev[4:2], gev[0] | gev[1]};
        dclr = f_acc(addr, rd, wr) | (m_ctrl[1] ? act : 4'd0);
        m_irq = |(m_flags & m_en);
        if (rd) m_rdata = f_read(addr);
        m_uf = gev[0];
        m_of = gev[1];
        for (int k = 0; k < 3; k++) m_cc[k] = m_ctrl[2+k] ? cmp[k] : gev[2+k];
        m_flags = (m_flags & ~clr) | gev;
        m_dma   = dset | (m_dma & ~dclr);
        if (wr && addr == 4'd0) m_ctrl = wdata[4:0];
        if (wr && addr == 4'd3) m_en   = wdata[7:0];
    endtask

    task automatic compare_all();
        chk("R3 irq", 32'(irq), 32'(m_irq));
        chk("R7 dma_req", 32'(dma), 32'(m_dma));
        chk("R5 uf/of pulse", 32'({uf_o, of_o}), 32'({m_uf, m_of}));
        chk("R6 channel outputs", 32'(cc_o), 32'(m_cc));
        chk("R11 rdata", rdata, m_rdata);
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        #2;
        compare_all();
        @(negedge clk);
    endtask

    task automatic set_idle();
        halt = 0; uf = 0; of = 0; cc = 0; cb = 0; cmp = 0; act = 0;
        addr = 0; rd = 0; wr = 0; wdata = 0;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        set_idle(); wr = 1; addr = a; wdata = d; step(); set_idle();
    endtask

    task automatic rd_reg(input logic [3:0] a);
        set_idle(); rd = 1; addr = a; step(); set_idle();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Watchdog
    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        set_idle();
        m_flags = 0; m_en = 0; m_ctrl = 0; m_dma = 0; m_irq = 0;
        m_uf = 0; m_of = 0; m_cc = 0; m_rdata = 0;
        uf = 1; cc = 3'b111;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state of all outputs
        chk("R1 reset outputs", {rdata[27:0], irq, dma[2:0]} | 32'({uf_o, of_o, cc_o, dma[3]}), 32'd0);
        @(negedge clk);
        set_idle();
        rst_n = 1;
        rd_reg(4'd1);
        chk("R1 flags after reset", rdata, 32'd0);

        // R11: enable readback
        wr_reg(4'd3, 32'hFF);
        rd_reg(4'd3);
        chk("R11 enable readback", rdata, 32'hFF);

        // R2, R3: sticky flag and interrupt
        uf = 1; step(); set_idle();
        step();
        chk("R3 irq after flag", 32'(irq), 32'd1);
        rd_reg(4'd1);
        chk("R2 underflow flag sticky", rdata, 32'd1);

        // R4: set in same cycle as clear wins, then plain clear
        wr = 1; addr = 4'd2; wdata = 32'hFF; uf = 1; step(); set_idle();
        rd_reg(4'd1);
        chk("R4 set wins over clear", rdata, 32'd1);
        wr_reg(4'd2, 32'h1);
        rd_reg(4'd1);
        chk("R4 flag cleared", rdata, 32'd0);

        // R7: top-buffer access clears underflow/overflow request
        chk("R7 request pending", 32'(dma), 32'd1);
        wr_reg(4'd5, 32'h0);
        chk("R7 cleared by top-buffer write", 32'(dma), 32'd0);

        // R8: DMA clear leaves flags
        cc = 3'b001; step(); set_idle();
        rd_reg(4'd6);
        chk("R8 request cleared by capture read", 32'(dma), 32'd0);
        rd_reg(4'd1);
        chk("R8 flag kept", rdata, 32'd4);

        // R9: clear on DMA active
        wr_reg(4'd0, 32'h2);
        cc = 3'b010; step(); set_idle();
        chk("R9 request set", 32'(dma), 32'h4);
        act = 4'b0100; step(); set_idle();
        chk("R9 cleared by active", 32'(dma), 32'd0);
        wr_reg(4'd0, 32'h0);
        cc = 3'b010; step(); set_idle();
        act = 4'b0100; step(); set_idle();
        chk("R9 active ignored when off", 32'(dma), 32'h4);

        // R10: debug freeze
        wr_reg(4'd2, 32'hFF);
        rd_reg(4'd8);
        halt = 1; uf = 1; of = 1; cc = 3'b111; cb = 3'b111; step(); set_idle();
        chk("R10 frozen outputs", 32'({uf_o, of_o, cc_o, dma}), 32'd0);
        rd_reg(4'd1);
        chk("R10 no flags while frozen", rdata, 32'd0);
        wr_reg(4'd0, 32'h1);
        halt = 1; uf = 1; step(); set_idle();
        chk("R10 events run with debug-run", 32'(uf_o), 32'd1);
        wr_reg(4'd4, 32'h0);

        // R6: level mode on channel 0, R5: pulse mode
        wr_reg(4'd0, 32'h4);
        cmp = 3'b001; step();
        chk("R6 level high", 32'(cc_o[0]), 32'd1);
        step();
        chk("R6 level held", 32'(cc_o[0]), 32'd1);
        cmp = 3'b000; step(); set_idle();
        chk("R6 level low", 32'(cc_o[0]), 32'd0);
        wr_reg(4'd0, 32'h0);
        cc = 3'b001; cmp = 3'b001; step(); set_idle();
        chk("R5 pulse high", 32'(cc_o[0]), 32'd1);
        cmp = 3'b001; step(); set_idle();
        chk("R5 pulse one cycle", 32'(cc_o[0]), 32'd0);

        // Constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            halt  = ($urandom % 12) == 0;
            uf    = ($urandom % 8) == 0;
            of    = ($urandom % 8) == 0;
            for (int k = 0; k < 3; k++) begin
                cc[k]  = ($urandom % 6) == 0;
                cb[k]  = ($urandom % 10) == 0;
                cmp[k] = ($urandom % 2) == 0;
            end
            act   = 4'($urandom % 16) & 4'($urandom % 16);
            rd    = ($urandom % 3) == 0;
            wr    = ($urandom % 4) == 0;
            addr  = 4'($urandom % 12);
            wdata = $urandom;
            step();
        end
        set_idle();
        step();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule